// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block is a purely combinational 16-bit binary adder. It takes two 16-bit operands and a carry-in, and returns a 16-bit sum and a carry-out. It is meant to sit inside a larger datapath, such as the arithmetic path of an ALU, where the carry chain is the critical timing path but area must stay close to that of a ripple adder.

The operand is cut into five groups of 2, 2, 3, 4 and 5 bits, from the least to the most significant end. The lowest group is a plain ripple adder fed by the external carry-in. Each higher group adds its slice once, with its local carry-in held at zero. It then forms the carry-in-one result by incrementing that (n+1)-bit value with an increment converter, not with a second adder. A 2:1 multiplexer per group selects one of the two results using the carry that leaves the group below. The carry selected by the top group is the block's carry-out.

Top module: `sqrt_csla_add`

## Requirements
- R1: For every operand pair and carry-in, {carry_out, sum_out} equals the 17-bit value op_a + op_b + carry_in.
- R2: With both operands 0xFFFF and carry_in 1, sum_out is 0xFFFF and carry_out is 1.
- R3: With both operands zero and carry_in 0, sum_out is 0x0000 and carry_out is 0.
- R4: A carry produced in one group reaches the next group across each of the four group boundaries, which sit at bit positions 2, 4, 7 and 11.
- R5: The carry leaving group g equals the carry of the true sum of all operand bits below that group's upper boundary plus carry_in, for every group.
- R6: When op_a + op_b equals 0xFFFF, carry_in 1 wraps sum_out to 0x0000 and sets carry_out to 1. With carry_in 0 the sum stays 0xFFFF and carry_out stays 0.
- R7: The outputs depend only on the present inputs. They settle without any clock edge, and no earlier input pattern affects a later result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The block holds no state, so a fault in one group's select or increment logic shows at the ports as soon as the inputs change. It appears as a wrong bit field that starts at that group's base and, through the carry, may corrupt every higher group. The vectors place a carry exactly on each group boundary, so a broken converter or a swapped multiplexer input shows up as a sum that is off by a power of two at that boundary. Random operands and the all-ones wrap then exercise the top-bit OR term of each converter.

// File: rtl/csla_pkg.sv
// Package: group layout of the square-root carry-select adder.
// Assumes group widths are at least 1 and that the groups tile the operand.
package csla_pkg;

    localparam int NUM_GRP = 5;

    // Width of group idx, least significant group first.
    function automatic int grp_width(input int idx);
        case (idx)
            0:       return 2;
            1:       return 2;
            2:       return 3;
            3:       return 4;
            default: return 5;
        endcase
    endfunction

    // Bit position of the lowest bit of group idx.
    function automatic int grp_base(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) begin
            acc += grp_width(k);
        end
        return acc;
    endfunction

    localparam int SUM_W = grp_base(NUM_GRP);

endpackage

// File: rtl/rca_chain.sv
// Ripple-carry adder of N bits; the result carries the final carry as its top bit.
// Assumes N >= 1. Purely combinational.
module rca_chain #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         cin,
    output logic [N:0]   res
);

    logic [N:0] cy;

    assign cy[0] = cin;

    // One full adder per bit position.
    for (genvar i = 0; i < N; i++) begin : g_fa
        assign res[i]  = a[i] ^ b[i] ^ cy[i];
        assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
    end

    assign res[N] = cy[N];

endmodule

// File: rtl/bec_incr.sv
// Binary-to-excess-one converter: dout = din + 1 for an N-bit value.
// Assumes N >= 2 and that din never holds all ones. This holds because din is
// the carry-in-zero result of an (N-1)-bit add, so its top bit may be ORed.
module bec_incr #(
    parameter int N = 3
) (
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);

    logic [N-1:0] low_ones;

    assign low_ones[0] = 1'b1;

    // Prefix AND of all bits below position i.
    for (genvar i = 1; i < N; i++) begin : g_pre
        assign low_ones[i] = low_ones[i-1] & din[i-1];
    end

    assign dout[0] = ~din[0];

    // Middle bits toggle when every lower bit is one.
    for (genvar i = 1; i < N - 1; i++) begin : g_mid
        assign dout[i] = din[i] ^ low_ones[i];
    end

    assign dout[N-1] = din[N-1] | low_ones[N-1];

endmodule

// File: rtl/csla_group.sv
// One select group: an add with carry-in zero, an increment converter, and a
// multiplexer that picks the result by the carry from the group below.
// Assumes N >= 1. Purely combinational.
module csla_group #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sel,
    output logic [N:0]   res
);

    logic [N:0] zero_res;
    logic [N:0] one_res;

    rca_chain #(.N(N)) u_add0 (
        .a   (a),
        .b   (b),
        .cin (1'b0),
        .res (zero_res)
    );

    bec_incr #(.N(N + 1)) u_inc (
        .din  (zero_res),
        .dout (one_res)
    );

    // Pick the result that matches the incoming carry.
    always_comb begin
        res = sel ? one_res : zero_res;
    end

endmodule

// File: rtl/sqrt_csla_add.sv
// Top: 16-bit square-root carry-select adder built from growing groups.
// Group 0 ripples from carry_in; later groups select between zero-carry and
// incremented results. Assumes WIDTH equals the tiled group width.
module sqrt_csla_add #(
    parameter int WIDTH = csla_pkg::SUM_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out
);

    localparam int NG = csla_pkg::NUM_GRP;

    logic [NG:0] grp_carry;

    assign grp_carry[0] = carry_in;

    // One adder group per slice of the operand.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        localparam int GW = csla_pkg::grp_width(g);
        localparam int GB = csla_pkg::grp_base(g);
        logic [GW:0] blk;

        if (g == 0) begin : g_first
            rca_chain #(.N(GW)) u_rca (
                .a   (op_a[GB +: GW]),
                .b   (op_b[GB +: GW]),
                .cin (grp_carry[g]),
                .res (blk)
            );
        end else begin : g_sel
            csla_group #(.N(GW)) u_sel (
                .a   (op_a[GB +: GW]),
                .b   (op_b[GB +: GW]),
                .sel (grp_carry[g]),
                .res (blk)
            );
        end

        assign sum_out[GB +: GW] = blk[GW-1:0];
        assign grp_carry[g+1]    = blk[GW];
    end

    assign carry_out = grp_carry[NG];

endmodule

// File: rtl/sqrt_csla_chk.sv
// Checker for sqrt_csla_add: compares ports and group carries with arithmetic.
// Assumes inputs are stable when the combinational processes settle.
module sqrt_csla_chk #(
    parameter int WIDTH = csla_pkg::SUM_W
) (
    input logic [WIDTH-1:0]              op_a,
    input logic [WIDTH-1:0]              op_b,
    input logic                          carry_in,
    input logic [WIDTH-1:0]              sum_out,
    input logic                          carry_out,
    input logic [csla_pkg::NUM_GRP:0]    grp_carry
);

    localparam int NG = csla_pkg::NUM_GRP;

    logic [WIDTH:0] ref_total;

    // Arithmetic model of the full sum.
    always_comb begin
        ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    end

    // Port and group-carry checks.
    always_comb begin
        if (!$isunknown({op_a, op_b, carry_in, sum_out, carry_out})) begin
            AST_SUM_MATCH: assert ({carry_out, sum_out} == ref_total); // R1
            if (&op_a && &op_b && carry_in) begin
                AST_ALL_ONES: assert (&sum_out && carry_out); // R2
            end
            if (op_a == '0 && op_b == '0 && !carry_in) begin
                AST_ZERO_IN: assert (sum_out == '0 && !carry_out); // R3
            end
            if ((op_a ^ op_b) == '1 && (op_a & op_b) == '0 && carry_in) begin
                AST_CIN_WRAP: assert (sum_out == '0 && carry_out); // R6
            end
            for (int g = 1; g <= NG; g++) begin
                logic [WIDTH:0] mask;
                logic [WIDTH:0] part;
                mask = ({{WIDTH{1'b0}}, 1'b1} << csla_pkg::grp_base(g)) - 1'b1;
                part = ({1'b0, op_a} & mask) + ({1'b0, op_b} & mask)
                     + {{WIDTH{1'b0}}, carry_in};
                AST_GRP_CARRY: assert (grp_carry[g] == part[csla_pkg::grp_base(g)]); // R5
            end
        end
    end

endmodule

bind sqrt_csla_add sqrt_csla_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum_out   (sum_out),
    .carry_out (carry_out),
    .grp_carry (grp_carry)
);

// File: tb/sim_sqrt_csla_add.sv
// Bench for sqrt_csla_add: vector table, boundary walk, random vectors.
module sim_sqrt_csla_add;

    logic        clk;
    logic [15:0] op_a;
    logic [15:0] op_b;
    logic        carry_in;
    logic [15:0] sum_out;
    logic        carry_out;

    int checks;
    int fails;

    sqrt_csla_add u0 (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    // 250 MHz clock used only to pace stimulus.
    initial clk = 1'b0;
    always #2 clk = ~clk;

    // Vector: {a, b, cin, expected {cout, sum}}.
    localparam logic [49:0] VEC [12] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h00000},
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},
        {16'hFFFF, 16'h0000, 1'b1, 17'h10000},
        {16'h0003, 16'h0001, 1'b0, 17'h00004},
        {16'h000F, 16'h0001, 1'b0, 17'h00010},
        {16'h007F, 16'h0001, 1'b0, 17'h00080},
        {16'h07FF, 16'h0000, 1'b1, 17'h00800},
        {16'h8000, 16'h8000, 1'b0, 17'h10000},
        {16'h1234, 16'h4321, 1'b0, 17'h05555},
        {16'hABCD, 16'h1234, 1'b1, 17'h0BE02},
        {16'h5555, 16'hAAAA, 1'b1, 17'h10000},
        {16'hFFFE, 16'h0001, 1'b0, 17'h0FFFF}
    };

    task automatic apply(input logic [15:0] a, input logic [15:0] b,
                         input logic c, input logic [16:0] exp_v,
                         input string req);
        @(negedge clk);
        op_a = a;
        op_b = b;
        carry_in = c;
        #1;
        checks++;
        if ({carry_out, sum_out} !== exp_v) begin
            fails++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h",
                     req, a, b, c, {carry_out, sum_out}, exp_v);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #800000;
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        checks = 0;
        fails = 0;
        op_a = '0;
        op_b = '0;
        carry_in = 1'b0;

        // R1 table walk; rows also cover R2, R3, R4, R6.
        for (int i = 0; i < 12; i++) begin
            apply(VEC[i][49:34], VEC[i][33:18], VEC[i][17], VEC[i][16:0], "R1");
        end

        // R3 zero inputs give zero outputs.
        apply(16'h0000, 16'h0000, 1'b0, 17'h00000, "R3");
        // R2 all ones with carry in.
        apply(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R2");

        // R4 carry crossing each group boundary (bits 2, 4, 7, 11).
        apply(16'h0002, 16'h0002, 1'b0, 17'h00004, "R4");
        apply(16'h000C, 16'h0004, 1'b0, 17'h00010, "R4");
        apply(16'h0070, 16'h0010, 1'b0, 17'h00080, "R4");
        apply(16'h0780, 16'h0080, 1'b0, 17'h00800, "R4");
        // R5 carry rippling through all groups via carry_in only.
        apply(16'hF0F0, 16'h0F0F, 1'b1, 17'h10000, "R5");
        apply(16'h0FFF, 16'h0000, 1'b1, 17'h01000, "R5");

        // R6 wrap with and without carry in.
        apply(16'h00FF, 16'hFF00, 1'b1, 17'h10000, "R6");
        apply(16'h00FF, 16'hFF00, 1'b0, 17'h0FFFF, "R6");

        // R7 history has no effect: same inputs after different predecessors.
        apply(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R7");
        apply(16'h0001, 16'h0001, 1'b0, 17'h00002, "R7");
        apply(16'h0000, 16'h0000, 1'b0, 17'h00000, "R7");
        apply(16'h0001, 16'h0001, 1'b0, 17'h00002, "R7");

        // R1 random vectors against the arithmetic model.
        for (int i = 0; i < 300; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            logic        rc;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            apply(ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {16'h0000, rc}, "R1");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule